// File: doc/BRIEF.md
# Dual-Clock Mailbox Pair

This block holds two single-word message registers that carry data between two ports running on unrelated clocks, alongside (and independent of) the bulk FIFOs. Port A owns `clk_a` and port B owns `clk_b`. Mailbox 1 carries words from port A to port B. Mailbox 2 carries words from port B to port A. Each mailbox has an active-low flag in its writer's clock domain. A write drives the flag low. The flag stays low until the reader takes the word on its own clock and that event has crossed back to the writer's domain.

Each port has a mailbox-select input. When the select is high, the port's write or read strobe targets the mailbox. When it is low, the strobe belongs to the FIFO path and the mailbox ignores it. The same select steers the port's data output. With the select high, the output shows the incoming mailbox word. With it low, the output shows the FIFO output register supplied from outside. Each reader also gets a synchronized "mail waiting" indication, which tells it when the mailbox word is safe to sample.

Set and clear events cross between the domains as toggles through two-flop synchronizers. A word stays frozen from its write until the reader has consumed it. The reset of each direction's FIFO also empties that direction's mailbox.

Top module: `mbox_pair`

## Requirements
- R1: A clk_a edge with `a_we` and `a_mb_sel` high while `a_full_n` is high stores `a_din` into mailbox 1 and drives `a_full_n` low right after that edge.
- R2: A clk_b edge with `b_we` and `b_mb_sel` high while `b_full_n` is high stores `b_din` into mailbox 2 and drives `b_full_n` low right after that edge.
- R3: While a mailbox flag is low, further writes to that mailbox are ignored: the stored word and the flag are unchanged.
- R4: After a mailbox 1 write, `b_mail_valid` goes high within three clk_b cycles and stays high until port B reads. The same holds for mailbox 2 with `a_mail_valid` and clk_a. While a reader's valid is high, the writer's flag is low.
- R5: A clk_b edge with `b_re` and `b_mb_sel` high while `b_mail_valid` is high clears `b_mail_valid` right after that edge. `a_full_n` returns high within three clk_a cycles.
- R6: A clk_a edge with `a_re` and `a_mb_sel` high while `a_mail_valid` is high clears `a_mail_valid` right after that edge. `b_full_n` returns high within three clk_b cycles.
- R7: `b_dout` equals the mailbox 1 word when `b_mb_sel` is 1 and equals `b_fifo_q` when it is 0.
- R8: `a_dout` equals the mailbox 2 word when `a_mb_sel` is 1 and equals `a_fifo_q` when it is 0.
- R9: A write or read strobe with its port's `*_mb_sel` low has no effect on either mailbox: no flag falls and no valid clears.
- R10: `fifo1_rst_n` low resets mailbox 1: `a_full_n` is 1, `b_mail_valid` is 0, and the stored word is 0. `fifo2_rst_n` does the same for mailbox 2 (`b_full_n` 1, `a_mail_valid` 0, word 0).
- R11: A mailbox read strobe while the reader's valid is low is ignored. A later write is still delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| fifo1_rst_n | input | 1 | Active-low reset of the A-to-B direction, sampled synchronously in both clock domains |
| fifo2_rst_n | input | 1 | Active-low reset of the B-to-A direction, sampled synchronously in both clock domains |
| a_mb_sel | input | 1 | Port A targets the mailbox (1) or the FIFO (0) |
| a_we | input | 1 | Port A write strobe |
| a_re | input | 1 | Port A read strobe |
| a_din | input | DATA_W | Port A write data |
| a_fifo_q | input | DATA_W | FIFO2 output register data for port A |
| a_dout | output | DATA_W | Port A read data |
| a_full_n | output | 1 | Mailbox 1 flag, low while a word is outstanding |
| a_mail_valid | output | 1 | Mailbox 2 word waiting for port A |
| b_mb_sel | input | 1 | Port B targets the mailbox (1) or the FIFO (0) |
| b_we | input | 1 | Port B write strobe |
| b_re | input | 1 | Port B read strobe |
| b_din | input | DATA_W | Port B write data |
| b_fifo_q | input | DATA_W | FIFO1 output register data for port B |
| b_dout | output | DATA_W | Port B read data |
| b_full_n | output | 1 | Mailbox 2 flag, low while a word is outstanding |
| b_mail_valid | output | 1 | Mailbox 1 word waiting for port B |

## Verification
The assertions assume that each direction reset is held low for at least four edges of both clocks, so every flop in both domains has cleared before either side runs again. They also assume that the strobes and selects change only away from their own clock edge. The checks that compare a writer-side flag with a reader-side valid rely on the toggles being quiet during a reset. The bench meets these assumptions: it drives each port's inputs on the falling edge of that port's clock, holds resets for six cycles of the slower clock, and uses clock periods of 10 and 14 time units, so the edges of the two domains drift against each other.

// File: rtl/mbox_pkg.sv
// Shared constants and helpers for the mailbox pair.
// Assumes: synchronizer depth of at least two flops.
package mbox_pkg;
    localparam int unsigned MBOX_SYNC_STAGES = 2;

    // A mailbox is occupied when the write and read toggles disagree.
    function automatic logic mbox_occupied(input logic wr_tog, input logic rd_tog);
        return wr_tog ^ rd_tog;
    endfunction
endpackage

// File: rtl/mbox_tsync.sv
// Multi-flop synchronizer for a level or toggle signal entering the clk domain.
// Assumes: input changes at most once per few destination cycles (toggle use),
// STAGES >= 2, synchronous active-low reset in the destination domain.
module mbox_tsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_chan.sv
// One-direction mailbox: writer domain holds the word and the write toggle,
// reader domain holds the read toggle. Each toggle crosses to the other side.
// Assumes: wrst_n and rrst_n are the same reset held for >= 4 cycles of both
// clocks; the word is sampled by the reader only while r_full is high.
module mbox_chan
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = MBOX_SYNC_STAGES
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    output logic              w_full,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_req,
    output logic              r_full,
    output logic [DATA_W-1:0] mail_q
);
    logic              wr_tog;
    logic              rd_tog;
    logic              wr_tog_in_r;
    logic              rd_tog_in_w;
    logic              wr_accept;
    logic              rd_accept;
    logic [DATA_W-1:0] word_q;

    assign w_full    = mbox_occupied(wr_tog, rd_tog_in_w);
    assign r_full    = mbox_occupied(wr_tog_in_r, rd_tog);
    assign wr_accept = wr_req && !w_full;
    assign rd_accept = rd_req && r_full;
    assign mail_q    = word_q;

    // Writer side: capture the word and flip the write toggle on an accepted write.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wr_tog <= 1'b0;
            word_q <= '0;
        end else if (wr_accept) begin
            wr_tog <= ~wr_tog;
            word_q <= wdata;
        end
    end

    // Reader side: flip the read toggle when a waiting word is consumed.
    always_ff @(posedge rclk) begin
        if (!rrst_n)        rd_tog <= 1'b0;
        else if (rd_accept) rd_tog <= ~rd_tog;
    end

    mbox_tsync #(.STAGES(SYNC_STAGES)) u_wr_to_r (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wr_tog),
        .q     (wr_tog_in_r)
    );

    mbox_tsync #(.STAGES(SYNC_STAGES)) u_rd_to_w (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (rd_tog),
        .q     (rd_tog_in_w)
    );
endmodule

// File: rtl/mbox_pair.sv
// Two opposite-direction mailboxes between port A (clk_a) and port B (clk_b),
// with active-low occupancy flags for the writers, valid indications for the
// readers, and per-port steering between mailbox and FIFO output data.
// Assumes: each fifoN_rst_n is held low for >= 4 edges of both clocks.
module mbox_pair
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = MBOX_SYNC_STAGES
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              fifo1_rst_n,
    input  logic              fifo2_rst_n,
    input  logic              a_mb_sel,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] a_fifo_q,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_full_n,
    output logic              a_mail_valid,
    input  logic              b_mb_sel,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] b_fifo_q,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_full_n,
    output logic              b_mail_valid
);
    logic [DATA_W-1:0] mail1_q;
    logic [DATA_W-1:0] mail2_q;
    logic              m1_w_full;
    logic              m2_w_full;

    // Mailbox 1: written by port A, read by port B, emptied by the FIFO1 reset.
    mbox_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
        .wclk   (clk_a),
        .wrst_n (fifo1_rst_n),
        .wr_req (a_we && a_mb_sel),
        .wdata  (a_din),
        .w_full (m1_w_full),
        .rclk   (clk_b),
        .rrst_n (fifo1_rst_n),
        .rd_req (b_re && b_mb_sel),
        .r_full (b_mail_valid),
        .mail_q (mail1_q)
    );

    // Mailbox 2: written by port B, read by port A, emptied by the FIFO2 reset.
    mbox_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
        .wclk   (clk_b),
        .wrst_n (fifo2_rst_n),
        .wr_req (b_we && b_mb_sel),
        .wdata  (b_din),
        .w_full (m2_w_full),
        .rclk   (clk_a),
        .rrst_n (fifo2_rst_n),
        .rd_req (a_re && a_mb_sel),
        .r_full (a_mail_valid),
        .mail_q (mail2_q)
    );

    assign a_full_n = ~m1_w_full;
    assign b_full_n = ~m2_w_full;

    // Output steering: mailbox word when selected, otherwise FIFO output register.
    always_comb begin
        a_dout = a_mb_sel ? mail2_q : a_fifo_q;
        b_dout = b_mb_sel ? mail1_q : b_fifo_q;
    end
endmodule

// File: rtl/mbox_pair_chk.sv
// Protocol checker for mbox_pair, attached with bind.
// Assumes: resets held for several edges of both clocks; inputs settle between edges.
module mbox_pair_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              fifo1_rst_n,
    input logic              fifo2_rst_n,
    input logic              a_mb_sel,
    input logic              a_we,
    input logic              a_re,
    input logic              b_mb_sel,
    input logic              b_we,
    input logic              b_re,
    input logic              a_full_n,
    input logic              b_full_n,
    input logic              a_mail_valid,
    input logic              b_mail_valid,
    input logic [DATA_W-1:0] mail1_q,
    input logic [DATA_W-1:0] mail2_q
);
    assert_wr_sets_flag_R1: assert property (@(posedge clk_a) disable iff (!fifo1_rst_n)
        (a_we && a_mb_sel && a_full_n) |=> !a_full_n);

    assert_wr_sets_flag_R2: assert property (@(posedge clk_b) disable iff (!fifo2_rst_n)
        (b_we && b_mb_sel && b_full_n) |=> !b_full_n);

    assert_word_frozen_m1_R3: assert property (@(posedge clk_a) disable iff (!fifo1_rst_n)
        !a_full_n |=> $stable(mail1_q));

    assert_word_frozen_m2_R3: assert property (@(posedge clk_b) disable iff (!fifo2_rst_n)
        !b_full_n |=> $stable(mail2_q));

    assert_valid_needs_flag_m1_R4: assert property (@(posedge clk_b) disable iff (!fifo1_rst_n)
        b_mail_valid |-> !a_full_n);

    assert_valid_needs_flag_m2_R4: assert property (@(posedge clk_a) disable iff (!fifo2_rst_n)
        a_mail_valid |-> !b_full_n);

    assert_read_clears_R5: assert property (@(posedge clk_b) disable iff (!fifo1_rst_n)
        (b_re && b_mb_sel && b_mail_valid) |=> !b_mail_valid);

    assert_read_clears_R6: assert property (@(posedge clk_a) disable iff (!fifo2_rst_n)
        (a_re && a_mb_sel && a_mail_valid) |=> !a_mail_valid);

    assert_fall_needs_write_a_R9: assert property (@(posedge clk_a) disable iff (!fifo1_rst_n)
        $fell(a_full_n) |-> $past(a_we && a_mb_sel));

    assert_fall_needs_write_b_R9: assert property (@(posedge clk_b) disable iff (!fifo2_rst_n)
        $fell(b_full_n) |-> $past(b_we && b_mb_sel));

    assert_reset_frees_m1_R10: assert property (@(posedge clk_a)
        !fifo1_rst_n |=> (a_full_n && mail1_q == '0));

    assert_reset_frees_m2_R10: assert property (@(posedge clk_b)
        !fifo2_rst_n |=> (b_full_n && mail2_q == '0));
endmodule

bind mbox_pair mbox_pair_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_a        (clk_a),
    .clk_b        (clk_b),
    .fifo1_rst_n  (fifo1_rst_n),
    .fifo2_rst_n  (fifo2_rst_n),
    .a_mb_sel     (a_mb_sel),
    .a_we         (a_we),
    .a_re         (a_re),
    .b_mb_sel     (b_mb_sel),
    .b_we         (b_we),
    .b_re         (b_re),
    .a_full_n     (a_full_n),
    .b_full_n     (b_full_n),
    .a_mail_valid (a_mail_valid),
    .b_mail_valid (b_mail_valid),
    .mail1_q      (mail1_q),
    .mail2_q      (mail2_q)
);

// File: tb/mbox_pair_test.sv
// Directed bench for mbox_pair: one task per scenario, each checking its results.
module mbox_pair_test;
    localparam int unsigned DATA_W       = 32;
    localparam time         CLK_A_PERIOD = 10;
    localparam time         CLK_B_PERIOD = 14;

    logic              clk_a = 1'b0;
    logic              clk_b = 1'b0;
    logic              fifo1_rst_n = 1'b0;
    logic              fifo2_rst_n = 1'b0;
    logic              a_mb_sel = 1'b0, a_we = 1'b0, a_re = 1'b0;
    logic              b_mb_sel = 1'b0, b_we = 1'b0, b_re = 1'b0;
    logic [DATA_W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
    logic [DATA_W-1:0] a_dout, b_dout;
    logic              a_full_n, b_full_n, a_mail_valid, b_mail_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
    always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

    mbox_pair #(.DATA_W(DATA_W)) uut (
        .clk_a(clk_a), .clk_b(clk_b),
        .fifo1_rst_n(fifo1_rst_n), .fifo2_rst_n(fifo2_rst_n),
        .a_mb_sel(a_mb_sel), .a_we(a_we), .a_re(a_re), .a_din(a_din),
        .a_fifo_q(a_fifo_q), .a_dout(a_dout), .a_full_n(a_full_n), .a_mail_valid(a_mail_valid),
        .b_mb_sel(b_mb_sel), .b_we(b_we), .b_re(b_re), .b_din(b_din),
        .b_fifo_q(b_fifo_q), .b_dout(b_dout), .b_full_n(b_full_n), .b_mail_valid(b_mail_valid)
    );

    task automatic check(input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic a_access(input logic we, input logic re, input logic sel,
                            input logic [DATA_W-1:0] d);
        @(negedge clk_a);
        a_we = we; a_re = re; a_mb_sel = sel; a_din = d;
        @(negedge clk_a);
        a_we = 1'b0; a_re = 1'b0; a_mb_sel = 1'b0;
    endtask

    task automatic b_access(input logic we, input logic re, input logic sel,
                            input logic [DATA_W-1:0] d);
        @(negedge clk_b);
        b_we = we; b_re = re; b_mb_sel = sel; b_din = d;
        @(negedge clk_b);
        b_we = 1'b0; b_re = 1'b0; b_mb_sel = 1'b0;
    endtask

    task automatic wait_b_valid(input string req, input logic exp);
        int n = 0;
        while (b_mail_valid !== exp && n < 3) begin @(negedge clk_b); n++; end
        check(req, "b_mail_valid within 3 clk_b", {31'b0, b_mail_valid}, {31'b0, exp});
    endtask

    task automatic wait_a_valid(input string req, input logic exp);
        int n = 0;
        while (a_mail_valid !== exp && n < 3) begin @(negedge clk_a); n++; end
        check(req, "a_mail_valid within 3 clk_a", {31'b0, a_mail_valid}, {31'b0, exp});
    endtask

    task automatic wait_a_full_n(input string req, input logic exp);
        int n = 0;
        while (a_full_n !== exp && n < 3) begin @(negedge clk_a); n++; end
        check(req, "a_full_n within 3 clk_a", {31'b0, a_full_n}, {31'b0, exp});
    endtask

    task automatic wait_b_full_n(input string req, input logic exp);
        int n = 0;
        while (b_full_n !== exp && n < 3) begin @(negedge clk_b); n++; end
        check(req, "b_full_n within 3 clk_b", {31'b0, b_full_n}, {31'b0, exp});
    endtask

    task automatic apply_reset(input logic r1, input logic r2);
        @(negedge clk_b);
        if (r1) fifo1_rst_n = 1'b0;
        if (r2) fifo2_rst_n = 1'b0;
        repeat (6) @(negedge clk_b);
        fifo1_rst_n = 1'b1; fifo2_rst_n = 1'b1;
        repeat (2) @(negedge clk_b);
    endtask

    // Reset state and FIFO-side steering (R10, R7, R8).
    task automatic t_reset_state();
        check("R10", "a_full_n after reset", {31'b0, a_full_n}, 32'd1);
        check("R10", "b_full_n after reset", {31'b0, b_full_n}, 32'd1);
        check("R10", "b_mail_valid after reset", {31'b0, b_mail_valid}, 32'd0);
        check("R10", "a_mail_valid after reset", {31'b0, a_mail_valid}, 32'd0);
        a_fifo_q = 32'hA5A5_0001; b_fifo_q = 32'h5A5A_0002;
        a_mb_sel = 1'b1; b_mb_sel = 1'b1; #1;
        check("R10", "mailbox 2 word after reset", a_dout, 32'h0);
        check("R10", "mailbox 1 word after reset", b_dout, 32'h0);
        a_mb_sel = 1'b0; b_mb_sel = 1'b0; #1;
        check("R8", "a_dout follows a_fifo_q", a_dout, 32'hA5A5_0001);
        check("R7", "b_dout follows b_fifo_q", b_dout, 32'h5A5A_0002);
    endtask

    // Mailbox 1 full round trip (R1, R3, R4, R5, R7).
    task automatic t_mail1_trip(input logic [DATA_W-1:0] d);
        a_access(1'b1, 1'b0, 1'b1, d);
        check("R1", "a_full_n right after write", {31'b0, a_full_n}, 32'd0);
        wait_b_valid("R4", 1'b1);
        a_access(1'b1, 1'b0, 1'b1, ~d);
        check("R3", "a_full_n after blocked write", {31'b0, a_full_n}, 32'd0);
        @(negedge clk_b); b_mb_sel = 1'b1; #1;
        check("R7", "b_dout shows mailbox 1", b_dout, d);
        check("R3", "mailbox 1 kept first word", b_dout, d);
        b_mb_sel = 1'b0;
        b_access(1'b0, 1'b1, 1'b1, '0);
        check("R5", "b_mail_valid cleared by read", {31'b0, b_mail_valid}, 32'd0);
        wait_a_full_n("R5", 1'b1);
    endtask

    // Mailbox 2 full round trip (R2, R3, R4, R6, R8).
    task automatic t_mail2_trip(input logic [DATA_W-1:0] d);
        b_access(1'b1, 1'b0, 1'b1, d);
        check("R2", "b_full_n right after write", {31'b0, b_full_n}, 32'd0);
        wait_a_valid("R4", 1'b1);
        b_access(1'b1, 1'b0, 1'b1, d ^ 32'hFFFF_0000);
        check("R3", "b_full_n after blocked write", {31'b0, b_full_n}, 32'd0);
        @(negedge clk_a); a_mb_sel = 1'b1; #1;
        check("R8", "a_dout shows mailbox 2", a_dout, d);
        a_mb_sel = 1'b0;
        a_access(1'b0, 1'b1, 1'b1, '0);
        check("R6", "a_mail_valid cleared by read", {31'b0, a_mail_valid}, 32'd0);
        wait_b_full_n("R6", 1'b1);
    endtask

    // Strobes with select low leave the mailboxes alone (R9).
    task automatic t_select_low();
        a_access(1'b1, 1'b0, 1'b0, 32'h1111_2222);
        repeat (4) @(negedge clk_b);
        check("R9", "a_full_n after FIFO-side write", {31'b0, a_full_n}, 32'd1);
        check("R9", "b_mail_valid after FIFO-side write", {31'b0, b_mail_valid}, 32'd0);
        a_access(1'b1, 1'b0, 1'b1, 32'h3333_4444);
        wait_b_valid("R4", 1'b1);
        b_access(1'b0, 1'b1, 1'b0, '0);
        repeat (3) @(negedge clk_b);
        check("R9", "b_mail_valid after FIFO-side read", {31'b0, b_mail_valid}, 32'd1);
        check("R9", "a_full_n after FIFO-side read", {31'b0, a_full_n}, 32'd0);
        b_access(1'b0, 1'b1, 1'b1, '0);
        wait_a_full_n("R5", 1'b1);
    endtask

    // Read of an empty mailbox is ignored, later write still delivered (R11).
    task automatic t_empty_read();
        b_access(1'b0, 1'b1, 1'b1, '0);
        repeat (3) @(negedge clk_a);
        check("R11", "a_full_n after empty read", {31'b0, a_full_n}, 32'd1);
        check("R11", "b_mail_valid after empty read", {31'b0, b_mail_valid}, 32'd0);
        a_access(1'b1, 1'b0, 1'b1, 32'hCAFE_F00D);
        check("R11", "a_full_n after write", {31'b0, a_full_n}, 32'd0);
        wait_b_valid("R11", 1'b1);
        @(negedge clk_b); b_mb_sel = 1'b1; #1;
        check("R11", "delivered word", b_dout, 32'hCAFE_F00D);
        b_mb_sel = 1'b0;
        b_access(1'b0, 1'b1, 1'b1, '0);
        wait_a_full_n("R11", 1'b1);
    endtask

    // Direction reset empties only its own mailbox (R10).
    task automatic t_fifo_reset();
        a_access(1'b1, 1'b0, 1'b1, 32'hDEAD_0001);
        b_access(1'b1, 1'b0, 1'b1, 32'hBEEF_0002);
        wait_b_valid("R10", 1'b1);
        wait_a_valid("R10", 1'b1);
        apply_reset(1'b1, 1'b0);
        check("R10", "a_full_n after FIFO1 reset", {31'b0, a_full_n}, 32'd1);
        check("R10", "b_mail_valid after FIFO1 reset", {31'b0, b_mail_valid}, 32'd0);
        b_mb_sel = 1'b1; #1;
        check("R10", "mailbox 1 word after FIFO1 reset", b_dout, 32'h0);
        b_mb_sel = 1'b0;
        check("R10", "mailbox 2 kept over FIFO1 reset", {31'b0, b_full_n}, 32'd0);
        apply_reset(1'b0, 1'b1);
        check("R10", "b_full_n after FIFO2 reset", {31'b0, b_full_n}, 32'd1);
        check("R10", "a_mail_valid after FIFO2 reset", {31'b0, a_mail_valid}, 32'd0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        #(CLK_B_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        apply_reset(1'b1, 1'b1);
        t_reset_state();
        t_mail1_trip(32'h1234_5678);
        t_mail2_trip(32'h8765_4321);
        t_mail1_trip(32'h0000_0001);
        t_select_low();
        t_empty_read();
        t_fifo_reset();
        t_mail2_trip(32'hFFFF_FFFF);
        done = 1'b1;
        report();
        $finish;
    end
endmodule